// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running nanosecond time-of-day value for a network controller. Each qualified reference tick moves the time forward by a fixed 8 ns. A signed correction, programmed by software in fractions of a nanosecond, is also applied on every tick. The correction goes into a 32-bit sub-nanosecond accumulator. When that accumulator carries or borrows, the nanosecond count gets one extra nanosecond or loses one. This lets the clock rate be trimmed in very fine steps while the nominal step stays fixed.

Software uses a small 32-bit register port with these word addresses:

| Address | Contents |
|---|---|
| 0 | Sub-nanosecond residue |
| 1 | Low 32 bits of the nanosecond count |
| 2 | High word of the nanosecond count |
| 3 | Correction |
| 4 | Control |

A read of the residue word captures the whole nanosecond count, so the low and high words that follow belong to the same instant. Setting the time takes a low-word write, which is staged, and then a high-word write, which commits both words.

Top module: `frac_tod_counter`

## Requirements
- R1: After reset the nanosecond count, the residue and the correction read as zero, and the control word reads 0x8000_0000, meaning stopped.
- R2: While running, each cycle with `tick_i` high adds exactly 8 ns when the correction is zero. Cycles with `tick_i` low change nothing.
- R3: With correction bit 31 clear, bits 30:0 are added to the residue on every tick. A carry out of bit 31 of the residue adds one further nanosecond.
- R4: With correction bit 31 set, bits 30:0 are subtracted from the residue on every tick. A borrow removes one nanosecond from that tick's 8 ns step.
- R5: The nanosecond count is 40 bits and wraps modulo 2^40. Bits 7:0 of the high word hold count bits 39:32, and high-word bits 31:8 always read zero.
- R6: A residue read returns the live residue and captures the nanosecond count at the same edge. Later low and high reads return that capture, even while time advances, until the next residue read.
- R7: A low-word write only stages its data. A high-word write loads the staged low word and the new high bits together and clears the residue. That write wins over a tick in the same cycle.
- R8: Control bit 31 set stops the counter, so ticks are ignored. Writing it 0 resumes counting. Other control bits read as zero.
- R9: Writes to the residue address have no effect.
- R10: Read data appears on `reg_rdata` the cycle after `reg_rd` and holds until the next read. The correction word reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-advance qualifier, one step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address: 0 residue, 1 low, 2 high, 3 correction, 4 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A residue that carries or borrows in the wrong direction makes the nanosecond count drift from the expected value. Because the checks accumulate over many ticks, that drift shows up within a few hundred ticks under random corrections. A stale or missing capture shows up on the very next low or high read after ticks have been issued. A bad load path shows up on the first residue/low/high read sequence after a high-word write.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int TOD_NS_W   = 40;
  localparam int TOD_FRAC_W = 32;
  localparam int TOD_DATA_W = 32;
  localparam int TOD_ADDR_W = 3;
  localparam int TOD_NOM_NS = 8;

  localparam logic [TOD_ADDR_W-1:0] ADR_RES  = 3'd0;
  localparam logic [TOD_ADDR_W-1:0] ADR_LO   = 3'd1;
  localparam logic [TOD_ADDR_W-1:0] ADR_HI   = 3'd2;
  localparam logic [TOD_ADDR_W-1:0] ADR_CORR = 3'd3;
  localparam logic [TOD_ADDR_W-1:0] ADR_CTL  = 3'd4;

  typedef struct packed {
    logic                  up;
    logic                  dn;
    logic [TOD_FRAC_W-1:0] frac;
  } frac_res_t;

  // Sign-magnitude correction applied to the residue; reports carry/borrow.
  function automatic frac_res_t frac_step(input logic [TOD_FRAC_W-1:0] frac,
                                          input logic [TOD_FRAC_W-1:0] corr);
    frac_res_t             r;
    logic [TOD_FRAC_W:0]   s;
    logic [TOD_FRAC_W:0]   mag;
    mag = {2'b00, corr[TOD_FRAC_W-2:0]};
    r   = '0;
    if (corr[TOD_FRAC_W-1]) begin
      s    = {1'b0, frac} - mag;
      r.dn = s[TOD_FRAC_W];
    end else begin
      s    = {1'b0, frac} + mag;
      r.up = s[TOD_FRAC_W];
    end
    r.frac = s[TOD_FRAC_W-1:0];
    return r;
  endfunction

  // Nominal step adjusted by one nanosecond for carry or borrow.
  function automatic logic [TOD_NS_W-1:0] ns_step(input logic [TOD_NS_W-1:0] ns,
                                                  input logic up, input logic dn);
    logic [TOD_NS_W-1:0] step;
    step = TOD_NS_W'(TOD_NOM_NS);
    if (up) step = step + 1'b1;
    if (dn) step = step - 1'b1;
    return ns + step;
  endfunction
endpackage

// File: rtl/tod_frac_accum.sv
module tod_frac_accum
  import tod_pkg::*;
#(
  parameter int FRAC_W = TOD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance_i,
  input  logic              clear_i,
  input  logic [FRAC_W-1:0] corr_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              carry_o,
  output logic              borrow_o
);
  logic [FRAC_W-1:0] frac_q;
  frac_res_t         nxt;

  always_comb begin
    nxt      = frac_step(frac_q, corr_i);
    carry_o  = advance_i & nxt.up;
    borrow_o = advance_i & nxt.dn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frac_q <= '0;
    else if (clear_i)   frac_q <= '0;
    else if (advance_i) frac_q <= nxt.frac;
  end

  assign frac_o = frac_q;

  AST_CARRY_BORROW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_o && borrow_o)); // R3

  AST_LOAD_CLEARS_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (frac_o == '0)); // R7

  AST_FRAC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance_i && !clear_i) |=> $stable(frac_o)); // R8
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter
  import tod_pkg::*;
#(
  parameter int NS_W = TOD_NS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance_i,
  input  logic            carry_i,
  input  logic            borrow_i,
  input  logic            load_i,
  input  logic [NS_W-1:0] load_val_i,
  output logic [NS_W-1:0] ns_o
);
  logic [NS_W-1:0] ns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ns_q <= '0;
    else if (load_i)    ns_q <= load_val_i;
    else if (advance_i) ns_q <= ns_step(ns_q, carry_i, borrow_i);
  end

  assign ns_o = ns_q;

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance_i && !load_i) |=> $stable(ns_o)); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ns_o == $past(load_val_i))); // R7
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter int NS_W   = TOD_NS_W,
  parameter int DATA_W = TOD_DATA_W,
  parameter int ADDR_W = TOD_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] frac_i,
  input  logic [NS_W-1:0]   ns_i,
  output logic              run_o,
  output logic [DATA_W-1:0] corr_o,
  output logic              load_o,
  output logic [NS_W-1:0]   load_val_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W  = NS_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic              stop_q;
  logic [DATA_W-1:0] corr_q;
  logic [DATA_W-1:0] stage_q;
  logic [NS_W-1:0]   snap_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_lo, wr_hi, wr_corr, wr_ctl, rd_res;

  always_comb begin
    wr_lo   = reg_wr && (reg_addr == ADR_LO);
    wr_hi   = reg_wr && (reg_addr == ADR_HI);
    wr_corr = reg_wr && (reg_addr == ADR_CORR);
    wr_ctl  = reg_wr && (reg_addr == ADR_CTL);
    rd_res  = reg_rd && (reg_addr == ADR_RES);
  end

  always_comb begin
    case (reg_addr)
      ADR_RES:  rd_mux = frac_i;
      ADR_LO:   rd_mux = snap_q[DATA_W-1:0];
      ADR_HI:   rd_mux = {{PAD_W{1'b0}}, snap_q[NS_W-1:DATA_W]};
      ADR_CORR: rd_mux = corr_q;
      ADR_CTL:  rd_mux = {stop_q, {(DATA_W-1){1'b0}}};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      corr_q  <= '0;
      stage_q <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctl)  stop_q  <= reg_wdata[DATA_W-1];
      if (wr_corr) corr_q  <= reg_wdata;
      if (wr_lo)   stage_q <= reg_wdata;
      if (rd_res)  snap_q  <= ns_i;
      if (reg_rd)  rdata_q <= rd_mux;
    end
  end

  assign run_o      = !stop_q;
  assign corr_o     = corr_q;
  assign load_o     = wr_hi;
  assign load_val_o = {reg_wdata[HI_W-1:0], stage_q};
  assign rdata_o    = rdata_q;

  AST_HI_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_HI) |=> (rdata_o[DATA_W-1:HI_W] == '0)); // R5

  AST_SNAP_ONLY_ON_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_res |=> $stable(snap_q)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/frac_tod_counter.sv
module frac_tod_counter
  import tod_pkg::*;
#(
  parameter int NS_W   = TOD_NS_W,
  parameter int DATA_W = TOD_DATA_W,
  parameter int ADDR_W = TOD_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic              run;
  logic              advance;
  logic              load;
  logic              carry, borrow;
  logic [DATA_W-1:0] corr;
  logic [DATA_W-1:0] frac;
  logic [NS_W-1:0]   ns;
  logic [NS_W-1:0]   load_val;

  assign advance = run & tick_i;

  tod_regif #(.NS_W(NS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .frac_i(frac), .ns_i(ns),
    .run_o(run), .corr_o(corr), .load_o(load), .load_val_o(load_val),
    .rdata_o(reg_rdata)
  );

  tod_frac_accum #(.FRAC_W(DATA_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .advance_i(advance), .clear_i(load),
    .corr_i(corr), .frac_o(frac), .carry_o(carry), .borrow_o(borrow)
  );

  tod_ns_counter #(.NS_W(NS_W)) u_ns (
    .clk(clk), .rst_n(rst_n), .advance_i(advance), .carry_i(carry),
    .borrow_i(borrow), .load_i(load), .load_val_i(load_val), .ns_o(ns)
  );
endmodule

// File: tb/frac_tod_counter_test.sv
module frac_tod_counter_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic [39:0] m_ns = '0;
  logic [31:0] m_frac = '0;
  logic [31:0] m_corr = '0;
  logic        m_stop = 1'b1;
  logic [31:0] m_stage = '0;
  logic [39:0] m_snap = '0;
  logic [31:0] exp_rd = '0;

  always #(CLK_NS/2) clk = ~clk;

  frac_tod_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Combined fixed-point view: time = ns * 2^32 + residue, modulo 2^72.
  task automatic step();
    logic [71:0] t;
    if (reg_rd) begin
      case (reg_addr)
        3'd0: begin exp_rd = m_frac; m_snap = m_ns; end
        3'd1: exp_rd = m_snap[31:0];
        3'd2: exp_rd = {24'd0, m_snap[39:32]};
        3'd3: exp_rd = m_corr;
        3'd4: exp_rd = {m_stop, 31'd0};
        default: exp_rd = '0;
      endcase
    end
    if (tick_i && !m_stop) begin
      t = {m_ns, m_frac};
      if (m_corr[31]) t = t + {40'd8, 32'd0} - {41'd0, m_corr[30:0]};
      else            t = t + {40'd8, 32'd0} + {41'd0, m_corr[30:0]};
      m_ns = t[71:32];
      m_frac = t[31:0];
    end
    if (reg_wr) begin
      case (reg_addr)
        3'd1: m_stage = reg_wdata;
        3'd2: begin m_ns = {reg_wdata[7:0], m_stage}; m_frac = '0; end
        3'd3: m_corr = reg_wdata;
        3'd4: m_stop = reg_wdata[31];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input string req);
    reg_rd = 1'b1; reg_addr = a;
    step();
    reg_rd = 1'b0;
    chk(req, reg_rdata, exp_rd);
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) step();
    tick_i = 1'b0;
  endtask

  task automatic read_time(input string req);
    do_read(3'd0, req);
    do_read(3'd1, req);
    do_read(3'd2, req);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_time("R1 reset time");
    do_read(3'd3, "R1 reset correction");
    do_read(3'd4, "R1 reset control");

    // R8 ticks while stopped are ignored
    ticks(5);
    read_time("R8 stopped after reset");

    // R2 nominal step, and idle cycles
    do_write(3'd4, 32'h0);
    ticks(10);
    step(); step();
    read_time("R2 nominal 8ns steps");
    do_read(3'd4, "R8 control running");

    // R3 positive correction
    do_write(3'd3, 32'h4000_0000);
    ticks(4);
    read_time("R3 positive correction carry");
    do_read(3'd3, "R10 correction readback");

    // R4 negative correction
    do_write(3'd3, 32'hC000_0000);
    ticks(4);
    read_time("R4 negative correction borrow");
    ticks(3);
    read_time("R4 borrow continues");

    // R7 staged load, R5 wrap and reserved bits
    do_write(3'd3, 32'h0);
    do_write(3'd1, 32'hFFFF_FFF8);
    ticks(2);
    read_time("R7 low write only staged");
    do_write(3'd3, 32'h0000_1000);
    ticks(1);
    do_write(3'd2, 32'hABCD_EFFF);
    read_time("R7 high write commits and clears residue");
    do_write(3'd3, 32'h0);
    ticks(1);
    read_time("R5 wrap modulo 2^40");

    // R7 load wins over a same-cycle tick
    do_write(3'd1, 32'h0000_0100);
    tick_i = 1'b1;
    do_write(3'd2, 32'h0000_0001);
    tick_i = 1'b0;
    read_time("R7 load over tick");

    // R6 snapshot persists while time advances
    do_read(3'd0, "R6 snapshot residue");
    ticks(7);
    do_read(3'd1, "R6 low from snapshot");
    do_read(3'd2, "R6 high from snapshot");

    // R9 residue writes ignored
    do_write(3'd3, 32'h1234_5678);
    ticks(3);
    do_write(3'd0, 32'hFFFF_FFFF);
    read_time("R9 residue write ignored");

    // R8 stop again
    do_write(3'd4, 32'h8000_0000);
    ticks(6);
    read_time("R8 stop holds time");
    do_read(3'd4, "R8 control stopped");
    do_write(3'd4, 32'h7FFF_FFFF);
    do_read(3'd4, "R8 only bit 31 kept");

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = int'($urandom % 10);
      tick_i = $urandom % 4 != 0;
      case (op)
        0, 1, 2, 3: step();
        4: begin
          logic [31:0] c;
          c = $urandom;
          if ($urandom % 2 == 0) c = {c[31], 11'd0, c[19:0]};
          do_write(3'd3, c);
        end
        5: read_time("R3 R4 random accumulate");
        6: do_read(3'($urandom % 5), "R10 random read");
        7: if ($urandom % 8 == 0) do_write(3'd4, {$urandom % 6 == 0, 31'd0}); else step();
        8: if ($urandom % 16 == 0) begin
             do_write(3'd1, $urandom);
             do_write(3'd2, $urandom);
           end else step();
        default: do_read(3'd2, "R5 R6 random high read");
      endcase
    end
    tick_i = 1'b0;
    read_time("R2 final time");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule